// File: doc/BRIEF.md
# Receive Line Idle Timeout Timer

This block watches an asynchronous serial receive line and reports when the line has been quiet for a programmed length of time. It is meant to mark the end of a reception burst whose length is not known in advance. A receiver that stores data with a DMA engine cannot otherwise tell when the sender has stopped. Each rising transition on the line restarts an internal silence counter. The counter advances only on ticks of a programmable prescaler. When it reaches a programmed compare value, a sticky interrupt flag is raised.

The line is brought into the clock domain by a flop synchroniser. A transition is recognised by comparing the synchronised level with its value one cycle earlier. The counter stops at the compare value rather than wrapping. The interrupt therefore fires exactly once per idle period and does not fire again until line activity restarts the count. The synchroniser flops reset to the idle-high level, so a line that is already idle after reset does not count as an edge.

Top module: `line_idle_timer`

## Requirements
- R1: The receive line passes through a two-stage synchroniser and one edge-history flop. A rising level driven on the line just after clock edge T clears the count at edge T+3.
- R2: Only a rising transition of the synchronised line restarts the count. A falling transition or a steady level in either state leaves the count running, or holding its saturated value.
- R3: The count rises by exactly one per prescaler tick. A tick occurs every divValue+1 clock cycles, with divValue=0 giving one tick per cycle. A restart also restarts the prescaler, so the count reaches k at edge T+3+k·(divValue+1).
- R4: The interrupt flag goes to 1 at the same edge where the count reaches cmpValue, which is edge T+3+cmpValue·(divValue+1) after an undisturbed restart.
- R5: The count saturates at cmpValue and never exceeds it while cmpValue is stable.
- R6: The interrupt flag stays at 1 until a one-cycle irqClear pulse, which clears it at the next edge. After a clear, it does not set again until a rising edge has restarted the count.
- R7: While enable is 0, the count and the prescaler are held at 0 and the flag is never set. Dropping enable in the middle of a count zeroes the count at the next edge.
- R8: With cmpValue equal to 0, the interrupt flag is never set and the count stays at 0.
- R9: During reset, the count reads 0 and the interrupt flag reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxLine | input | 1 | Asynchronous serial receive line being monitored |
| enable | input | 1 | 1 runs the timer; 0 holds the count and prescaler at zero |
| cmpValue | input | CNT_W | Silence length, in prescaler ticks, that raises the timeout |
| divValue | input | DIV_W | Prescaler divide value; one tick every divValue+1 cycles |
| irqClear | input | 1 | One-cycle pulse that clears the interrupt flag |
| irqFlag | output | 1 | Sticky timeout interrupt flag |
| count | output | CNT_W | Current silence count |

## Verification
The bench uses an 8-bit count and a 4-bit divide value. These small widths keep every timeout within a few dozen cycles, so saturation, re-arming and the cmpValue=0 corner all fit into a short run. Divide values of 0, 1 and 2 cover both the tick-every-cycle path and multi-cycle prescaling. For every restart, the bench predicts the exact edge at which the count and the flag change.

// File: rtl/idle_pkg.sv
package idle_pkg;

  // Strobes from the control side to the counting datapath
  typedef struct packed {
    logic restart;   // clear count (line rose, or timer disabled)
    logic tick;      // prescaler tick: advance the count
    logic clrIrq;    // software clear of the sticky flag
  } strobe_t;

endpackage

// File: rtl/idle_ctrl.sv
module idle_ctrl
  import idle_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxLine,
  input  logic             enable,
  input  logic [DIV_W-1:0] divValue,
  input  logic             irqClear,
  output strobe_t          strb
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevLvl;
  logic                   lineLvl;
  logic                   lineRise;
  logic [DIV_W-1:0]       preCnt;
  logic                   preWrap;

  // Synchroniser chain, reset to the idle-high level of a serial line
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      syncQ   <= '1;
      prevLvl <= 1'b1;
    end else begin
      syncQ   <= {syncQ[LAST-1:0], rxLine};
      prevLvl <= syncQ[LAST];
    end
  end

  assign lineLvl  = syncQ[LAST];
  assign lineRise = lineLvl & ~prevLvl;

  // Prescaler: restarted together with the silence counter
  assign preWrap = (preCnt == divValue);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      preCnt <= '0;
    end else if (!enable || lineRise) begin
      preCnt <= '0;
    end else if (preWrap) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  always_comb begin
    strb.restart = lineRise | ~enable;
    strb.tick    = enable & ~lineRise & preWrap;
    strb.clrIrq  = irqClear;
  end

  // R7: disabled timer keeps its prescaler at zero
  p_presc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (preCnt == '0));

  // R2: a rising edge is detected for a single cycle only
  p_rise_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lineRise |=> !lineRise);

endmodule

// File: rtl/idle_dpath.sv
module idle_dpath
  import idle_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_t          strb,
  input  logic [CNT_W-1:0] cmpValue,
  output logic [CNT_W-1:0] cnt,
  output logic             irqFlag
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic belowCmp;
  logic lastStep;
  logic setIrq;

  assign belowCmp = (cnt < cmpValue);
  assign lastStep = (cmpValue != '0) && (cnt == cmpValue - ONE);
  assign setIrq   = strb.tick && !strb.restart && lastStep;

  // Silence counter: cleared on restart, saturates at the compare value
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (strb.restart) begin
      cnt <= '0;
    end else if (strb.tick && belowCmp) begin
      cnt <= cnt + ONE;
    end
  end

  // Sticky timeout flag; a new match wins over a simultaneous clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irqFlag <= 1'b0;
    end else if (setIrq) begin
      irqFlag <= 1'b1;
    end else if (strb.clrIrq) begin
      irqFlag <= 1'b0;
    end
  end

  // R5: any non-clearing change is a single step taken from below the compare value
  p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt) && cnt != '0) |->
      (cnt == $past(cnt) + ONE && $past(cnt) < $past(cmpValue)));

  // R4: the flag rises only when the count has just hit the compare value
  p_rise_at_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irqFlag) |-> (cnt == $past(cmpValue)));

  // R6: the flag holds until cleared
  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irqFlag && !strb.clrIrq) |=> irqFlag);

endmodule

// File: rtl/line_idle_timer.sv
module line_idle_timer
  import idle_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxLine,
  input  logic             enable,
  input  logic [CNT_W-1:0] cmpValue,
  input  logic [DIV_W-1:0] divValue,
  input  logic             irqClear,
  output logic             irqFlag,
  output logic [CNT_W-1:0] count
);

  strobe_t strb;

  idle_ctrl #(.DIV_W(DIV_W), .SYNC_STAGES(2)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .rxLine   (rxLine),
    .enable   (enable),
    .divValue (divValue),
    .irqClear (irqClear),
    .strb     (strb)
  );

  idle_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .cmpValue (cmpValue),
    .cnt      (count),
    .irqFlag  (irqFlag)
  );

  // R8: a zero compare value never produces a timeout
  p_zero_cmp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpValue == '0 && !irqFlag) |=> !irqFlag);

endmodule

// File: tb/tb_line_idle_timer.sv
module tb_line_idle_timer;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 8;
  localparam int DIV_W      = 4;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             rxLine;
  logic             enable;
  logic [CNT_W-1:0] cmpValue;
  logic [DIV_W-1:0] divValue;
  logic             irqClear;
  logic             irqFlag;
  logic [CNT_W-1:0] count;

  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;

  typedef struct {
    int    at;
    logic  irq;
    int    cnt;
    string tag;
  } exp_t;

  exp_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  line_idle_timer #(.CNT_W(CNT_W), .DIV_W(DIV_W)) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .rxLine   (rxLine),
    .enable   (enable),
    .cmpValue (cmpValue),
    .divValue (divValue),
    .irqClear (irqClear),
    .irqFlag  (irqFlag),
    .count    (count)
  );

  function automatic void checkNow(logic eIrq, int eCnt, string tag);
    nChecks++;
    if (irqFlag !== eIrq || int'(count) != eCnt) begin
      nFails++;
      $display("FAIL %s cycle %0d: irq=%0b count=%0d, expected irq=%0b count=%0d",
               tag, cyc, irqFlag, count, eIrq, eCnt);
    end
  endfunction

  // Driver side: queue an expectation, kept in cycle order
  function automatic void expectAt(int at, logic eIrq, int eCnt, string tag);
    exp_t item;
    int   pos;
    item.at = at; item.irq = eIrq; item.cnt = eCnt; item.tag = tag;
    pos = expQ.size();
    for (int i = 0; i < expQ.size(); i++) begin
      if (expQ[i].at > at) begin
        pos = i;
        break;
      end
    end
    expQ.insert(pos, item);
  endfunction

  // Monitor: compare queued expectations away from the active edge
  always @(negedge clk) begin
    while (expQ.size() > 0 && expQ[0].at <= cyc) begin
      exp_t e;
      e = expQ.pop_front();
      if (e.at < cyc) begin
        nChecks++;
        nFails++;
        $display("FAIL %s: expectation for cycle %0d missed (now %0d), expected irq=%0b count=%0d",
                 e.tag, e.at, cyc, e.irq, e.cnt);
      end else begin
        checkNow(e.irq, e.cnt, e.tag);
      end
    end
  end

  task automatic waitNeg(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseClear();
    irqClear = 1'b1;
    waitNeg(1);
    irqClear = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    int c;
    rst_n = 1'b0; rxLine = 1'b0; enable = 1'b0;
    cmpValue = 8'd5; divValue = 4'd2; irqClear = 1'b0;
    waitNeg(3);
    checkNow(1'b0, 0, "R9 reset state");
    rst_n = 1'b1;

    // R7: disabled timer ignores activity and never times out
    waitNeg(2);
    rxLine = 1'b1;
    waitNeg(30);
    checkNow(1'b0, 0, "R7 disabled hold");
    rxLine = 1'b0;
    waitNeg(5);

    // R1/R3/R4/R5: basic timeout, cmp=5 div=2 -> 15 cycles after restart
    enable = 1'b1;
    waitNeg(5);
    c = cyc;
    rxLine = 1'b1;
    expectAt(c + 3,  1'b0, 0, "R1 restart latency");
    expectAt(c + 6,  1'b0, 1, "R3 first tick");
    expectAt(c + 17, 1'b0, 4, "R4 before match");
    expectAt(c + 18, 1'b1, 5, "R4 match edge");
    waitNeg(40);
    checkNow(1'b1, 5, "R5 saturated");

    // R6: clear, then no re-fire without a new edge
    c = cyc;
    expectAt(c + 1, 1'b0, 5, "R6 clear");
    pulseClear();
    waitNeg(20);
    checkNow(1'b0, 5, "R6 no refire");

    // R2: falling edge and steady low do not restart
    rxLine = 1'b0;
    waitNeg(10);
    checkNow(1'b0, 5, "R2 falling ignored");

    // R2: mid-burst fall then rise restarts only on the rise
    c = cyc;
    rxLine = 1'b1;
    expectAt(c + 3,  1'b0, 0, "R1 second restart");
    expectAt(c + 10, 1'b0, 2, "R2 fall keeps counting");
    expectAt(c + 25, 1'b0, 4, "R2 late rise restarted count");
    expectAt(c + 26, 1'b1, 5, "R4 match after second rise");
    waitNeg(4);
    rxLine = 1'b0;
    waitNeg(4);
    rxLine = 1'b1;
    waitNeg(30);
    pulseClear();

    // R3: divide of zero ticks every cycle, cmp=3
    divValue = 4'd0; cmpValue = 8'd3;
    rxLine = 1'b0;
    waitNeg(5);
    c = cyc;
    rxLine = 1'b1;
    expectAt(c + 3, 1'b0, 0, "R3 restart div0");
    expectAt(c + 5, 1'b0, 2, "R3 tick every cycle");
    expectAt(c + 6, 1'b1, 3, "R4 match div0");
    waitNeg(20);
    pulseClear();
    waitNeg(2);

    // R8: zero compare value never times out
    divValue = 4'd1; cmpValue = 8'd0;
    rxLine = 1'b0;
    waitNeg(5);
    c = cyc;
    rxLine = 1'b1;
    expectAt(c + 3, 1'b0, 0, "R8 restart");
    waitNeg(40);
    checkNow(1'b0, 0, "R8 zero compare idle");

    // R7: dropping enable mid-count zeroes the count, no timeout
    cmpValue = 8'd10;
    rxLine = 1'b0;
    waitNeg(5);
    c = cyc;
    rxLine = 1'b1;
    expectAt(c + 8, 1'b0, 2, "R3 div1 counting");
    waitNeg(9);
    enable = 1'b0;
    expectAt(c + 10, 1'b0, 0, "R7 enable drop");
    waitNeg(30);
    checkNow(1'b0, 0, "R7 no timeout while disabled");

    waitNeg(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule